// File: doc/BRIEF.md
# Analog Boundary Module Control Cell

This block is the digital control section of one analog boundary module sitting in a mixed-signal boundary-scan chain. It holds four boundary-register scan cells that capture, shift and update under the TAP controller's data-register state strobes. During capture, cell 0 samples the digital result of the pin comparator, so the comparator reading leaves the chip on the next shift.

The four cells shift through the chain, and an update latch loaded on Update-DR holds the control word. A combinational decoder turns that held word and the current instruction into enables for six analog switches. The first is the mission-path switch. Two drive a high or low level onto the pin. One ties the pin to a reference level, and two connect the pin to the two internal analog bus lines. A parameterised opcode marks the intrusive test instruction, which defaults to all zeros. Under any other instruction the mission path is forced closed and every test switch is open. The analog switches and the comparator are outside the block and appear only as enable bits and a single comparator bit.

Top module: `abm_ctrl`

## Requirements
- R1: While trst_ni is low, and afterwards until a new word is updated, all four cells and the held word are 0; with a non-test instruction sw_sd_o is 1 and the other five enables are 0, and scan_out_o is 0.
- R2: In a cycle with capture_dr_i high, cell 0 loads cmp_i and cells 1 to 3 load bits 1 to 3 of the held word. Capture takes priority over shift.
- R3: In a cycle with shift_dr_i high and capture_dr_i low, scan_in_i enters cell 3 and every cell moves one place toward cell 0. scan_out_o always shows cell 0. After four shifts the bit that went in first sits in cell 0, so a word shifted LSB first ends with word bit k in cell k.
- R4: The held word loads from the four cells only in a cycle with update_dr_i high. While it is held, capture and shift traffic leave the six enables unchanged.
- R5: When ir_i differs from the test opcode (default 0), sw_sd_o is 1 and the other five enables are 0, whatever word is held.
- R6: When ir_i equals the test opcode, sw_sd_o is 0. With held word 0x0, all six enables are 0.
- R7: Under the test opcode, held word 0x3 closes only sw_bus1_o and sw_bus2_o.
- R8: Under the test opcode, word 0xD closes only sw_bus1_o and sw_sh_o, and word 0xE closes only sw_bus2_o and sw_sh_o.
- R9: Under the test opcode, word 0x7 closes only sw_bus1_o, sw_bus2_o and sw_sl_o, and word 0xB closes only sw_bus1_o, sw_bus2_o and sw_sg_o.
- R10: Under the test opcode, every other word value leaves all six enables at 0. sw_sh_o and sw_sl_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| trst_ni | input | 1 | Asynchronous TAP reset, active low |
| ir_i | input | IR_W | Current instruction |
| capture_dr_i | input | 1 | TAP is in Capture-DR |
| shift_dr_i | input | 1 | TAP is in Shift-DR |
| update_dr_i | input | 1 | TAP is in Update-DR |
| scan_in_i | input | 1 | Serial data from the previous chain cell |
| cmp_i | input | 1 | Pin comparator result (1 = above threshold) |
| scan_out_o | output | 1 | Serial data to the next chain cell (cell 0) |
| sw_sd_o | output | 1 | Mission-path switch enable |
| sw_sh_o | output | 1 | Drive-high switch enable |
| sw_sl_o | output | 1 | Drive-low switch enable |
| sw_sg_o | output | 1 | Reference-level switch enable |
| sw_bus1_o | output | 1 | Analog bus line 1 switch enable |
| sw_bus2_o | output | 1 | Analog bus line 2 switch enable |

## Verification
Timing differs by path. A capture, shift or update strobe affects scan_out_o or the enables one tck edge later, through one register stage. An instruction change reaches the enables in the same cycle, with no register in between. The bench tags every expected item with the cycle in which it falls due: the strobe cycle plus one for strobes, and the same cycle for instruction changes. It samples one nanosecond before the next rising edge, after that cycle's inputs have settled. While a word is shifted through the chain, each shift cycle also checks the enables against the previously held word. This shows that only Update-DR moves them.

// File: rtl/abm_ctrl_pkg.sv
package abm_ctrl_pkg;

    // number of control cells per analog boundary module
    localparam int unsigned CTRL_BITS = 4;

    typedef struct packed {
        logic sd;    // mission path
        logic sh;    // drive high
        logic sl;    // drive low
        logic sg;    // reference level
        logic bus1;  // analog bus line 1
        logic bus2;  // analog bus line 2
    } abm_sw_t;

    // control words recognised under the test instruction
    localparam logic [CTRL_BITS-1:0] WORD_OPEN     = 4'h0;
    localparam logic [CTRL_BITS-1:0] WORD_BUS_BOTH = 4'h3;
    localparam logic [CTRL_BITS-1:0] WORD_BUS_LOW  = 4'h7;
    localparam logic [CTRL_BITS-1:0] WORD_BUS_REF  = 4'hB;
    localparam logic [CTRL_BITS-1:0] WORD_B1_HIGH  = 4'hD;
    localparam logic [CTRL_BITS-1:0] WORD_B2_HIGH  = 4'hE;

    localparam abm_sw_t SW_MISSION  = '{sd: 1'b1, default: 1'b0};
    localparam abm_sw_t SW_ALL_OPEN = '{default: 1'b0};

endpackage

// File: rtl/abm_scan_cells.sv
module abm_scan_cells #(
    parameter int unsigned N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         capture_i,
    input  logic         shift_i,
    input  logic         scan_in_i,
    input  logic         cmp_i,
    input  logic [N-1:1] held_hi_i,
    output logic [N-1:0] cells_o,
    output logic         scan_out_o
);

    typedef struct packed {
        logic [N-1:0] cells;
    } state_t;

    state_t       st_d, st_q;
    logic [N-1:0] cap_src;

    // cell 0 observes the pin comparator, the rest observe the held word
    for (genvar g = 0; g < N; g++) begin : g_cap
        if (g == 0) begin : g_cmp
            assign cap_src[g] = cmp_i;
        end else begin : g_held
            assign cap_src[g] = held_hi_i[g];
        end
    end

    always_comb begin
        st_d = st_q;
        if (capture_i) begin
            st_d.cells = cap_src;
        end else if (shift_i) begin
            st_d.cells = {scan_in_i, st_q.cells[N-1:1]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cells_o    = st_q.cells;
    assign scan_out_o = st_q.cells[0];

endmodule

// File: rtl/abm_update_reg.sv
module abm_update_reg #(
    parameter int unsigned N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [N-1:0] din_i,
    output logic [N-1:0] word_o
);

    typedef struct packed {
        logic [N-1:0] word;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.word = din_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;

endmodule

// File: rtl/abm_sw_decode.sv
module abm_sw_decode
    import abm_ctrl_pkg::*;
(
    input  logic [CTRL_BITS-1:0] word_i,
    input  logic                 test_mode_i,
    output abm_sw_t              sw_o
);

    abm_sw_t test_sw;

    always_comb begin
        test_sw = SW_ALL_OPEN;
        unique case (word_i)
            WORD_BUS_BOTH: begin
                test_sw.bus1 = 1'b1;
                test_sw.bus2 = 1'b1;
            end
            WORD_B1_HIGH: begin
                test_sw.bus1 = 1'b1;
                test_sw.sh   = 1'b1;
            end
            WORD_B2_HIGH: begin
                test_sw.bus2 = 1'b1;
                test_sw.sh   = 1'b1;
            end
            WORD_BUS_LOW: begin
                test_sw.bus1 = 1'b1;
                test_sw.bus2 = 1'b1;
                test_sw.sl   = 1'b1;
            end
            WORD_BUS_REF: begin
                test_sw.bus1 = 1'b1;
                test_sw.bus2 = 1'b1;
                test_sw.sg   = 1'b1;
            end
            default: test_sw = SW_ALL_OPEN;
        endcase
    end

    // outside the test instruction the pin stays on its mission path
    assign sw_o = test_mode_i ? test_sw : SW_MISSION;

endmodule

// File: rtl/abm_ctrl.sv
module abm_ctrl #(
    parameter int unsigned          IR_W        = 4,
    parameter logic [IR_W-1:0]      TEST_OPCODE = '0
) (
    input  logic            tck_i,
    input  logic            trst_ni,
    input  logic [IR_W-1:0] ir_i,
    input  logic            capture_dr_i,
    input  logic            shift_dr_i,
    input  logic            update_dr_i,
    input  logic            scan_in_i,
    input  logic            cmp_i,
    output logic            scan_out_o,
    output logic            sw_sd_o,
    output logic            sw_sh_o,
    output logic            sw_sl_o,
    output logic            sw_sg_o,
    output logic            sw_bus1_o,
    output logic            sw_bus2_o
);
    import abm_ctrl_pkg::*;

    localparam int unsigned N = CTRL_BITS;

    logic [N-1:0] cells_q;
    logic [N-1:0] word_q;
    logic         test_mode;
    abm_sw_t      sw;

    assign test_mode = (ir_i == TEST_OPCODE);

    abm_scan_cells #(.N(N)) u_cells (
        .clk_i      (tck_i),
        .rst_ni     (trst_ni),
        .capture_i  (capture_dr_i),
        .shift_i    (shift_dr_i),
        .scan_in_i  (scan_in_i),
        .cmp_i      (cmp_i),
        .held_hi_i  (word_q[N-1:1]),
        .cells_o    (cells_q),
        .scan_out_o (scan_out_o)
    );

    abm_update_reg #(.N(N)) u_update (
        .clk_i  (tck_i),
        .rst_ni (trst_ni),
        .load_i (update_dr_i),
        .din_i  (cells_q),
        .word_o (word_q)
    );

    abm_sw_decode u_decode (
        .word_i      (word_q),
        .test_mode_i (test_mode),
        .sw_o        (sw)
    );

    assign sw_sd_o   = sw.sd;
    assign sw_sh_o   = sw.sh;
    assign sw_sl_o   = sw.sl;
    assign sw_sg_o   = sw.sg;
    assign sw_bus1_o = sw.bus1;
    assign sw_bus2_o = sw.bus2;

endmodule

// File: rtl/abm_ctrl_chk.sv
module abm_ctrl_chk #(
    parameter int unsigned     IR_W        = 4,
    parameter logic [IR_W-1:0] TEST_OPCODE = '0,
    parameter int unsigned     N           = 4
) (
    input logic            tck_i,
    input logic            trst_ni,
    input logic [IR_W-1:0] ir_i,
    input logic            capture_dr_i,
    input logic            shift_dr_i,
    input logic            update_dr_i,
    input logic            scan_in_i,
    input logic            cmp_i,
    input logic            scan_out_o,
    input logic            sw_sd_o,
    input logic            sw_sh_o,
    input logic            sw_sl_o,
    input logic            sw_sg_o,
    input logic            sw_bus1_o,
    input logic            sw_bus2_o,
    input logic [N-1:0]    cells
);

    logic [5:0] sw_all;
    assign sw_all = {sw_sd_o, sw_sh_o, sw_sl_o, sw_sg_o, sw_bus1_o, sw_bus2_o};

    a_r2_capture_cmp: assert property (@(posedge tck_i) disable iff (!trst_ni)
        $past(capture_dr_i) |-> (scan_out_o == $past(cmp_i)));

    a_r3_shift_move: assert property (@(posedge tck_i) disable iff (!trst_ni)
        $past(shift_dr_i && !capture_dr_i) |->
            ((cells[N-1] == $past(scan_in_i)) && (cells[N-2:0] == $past(cells[N-1:1]))));

    a_r4_hold_enables: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (!$past(update_dr_i) && $stable(ir_i)) |-> $stable(sw_all));

    a_r5_mission_path: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (ir_i != TEST_OPCODE) |-> (sw_all == 6'b100000));

    a_r6_test_sd_open: assert property (@(posedge tck_i) disable iff (!trst_ni)
        (ir_i == TEST_OPCODE) |-> !sw_sd_o);

    a_r10_high_low_excl: assert property (@(posedge tck_i) disable iff (!trst_ni)
        !(sw_sh_o && sw_sl_o));

endmodule

bind abm_ctrl abm_ctrl_chk #(
    .IR_W        (IR_W),
    .TEST_OPCODE (TEST_OPCODE),
    .N           (N)
) u_chk (
    .tck_i        (tck_i),
    .trst_ni      (trst_ni),
    .ir_i         (ir_i),
    .capture_dr_i (capture_dr_i),
    .shift_dr_i   (shift_dr_i),
    .update_dr_i  (update_dr_i),
    .scan_in_i    (scan_in_i),
    .cmp_i        (cmp_i),
    .scan_out_o   (scan_out_o),
    .sw_sd_o      (sw_sd_o),
    .sw_sh_o      (sw_sh_o),
    .sw_sl_o      (sw_sl_o),
    .sw_sg_o      (sw_sg_o),
    .sw_bus1_o    (sw_bus1_o),
    .sw_bus2_o    (sw_bus2_o),
    .cells        (cells_q)
);

// File: tb/abm_ctrl_tb.sv
module abm_ctrl_tb;

    typedef struct {
        int         due;
        logic       chk_so;
        logic       so;
        logic [5:0] sw;   // {sd, sh, sl, sg, bus1, bus2}
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       trst_n = 1'b0;
    logic [3:0] ir = 4'hF;
    logic       cap = 1'b0, sh = 1'b0, upd = 1'b0, sin = 1'b0, cmp = 1'b0;
    logic       so;
    logic       sd_o, sh_o, sl_o, sg_o, b1_o, b2_o;

    item_t      q[$];
    int         cyc = 0;
    int         n_cmp = 0;
    int         n_bad = 0;
    logic [3:0] held = 4'h0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    abm_ctrl u_dut (
        .tck_i        (clk),
        .trst_ni      (trst_n),
        .ir_i         (ir),
        .capture_dr_i (cap),
        .shift_dr_i   (sh),
        .update_dr_i  (upd),
        .scan_in_i    (sin),
        .cmp_i        (cmp),
        .scan_out_o   (so),
        .sw_sd_o      (sd_o),
        .sw_sh_o      (sh_o),
        .sw_sl_o      (sl_o),
        .sw_sg_o      (sg_o),
        .sw_bus1_o    (b1_o),
        .sw_bus2_o    (b2_o)
    );

    function automatic logic [5:0] exp_sw(logic [3:0] i, logic [3:0] w);
        if (i != 4'h0) return 6'b100000;           // R5
        case (w)
            4'h3:    return 6'b000011;             // R7
            4'hD:    return 6'b010010;             // R8
            4'hE:    return 6'b010001;             // R8
            4'h7:    return 6'b001011;             // R9
            4'hB:    return 6'b000111;             // R9
            default: return 6'b000000;             // R6 / R10
        endcase
    endfunction

    task automatic push(int due, logic chk_so, logic exp_so, logic [5:0] esw, string req);
        item_t it;
        it.due = due; it.chk_so = chk_so; it.so = exp_so; it.sw = esw; it.req = req;
        q.push_back(it);
    endtask

    // monitor: samples 1 ns before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #4;
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                logic [5:0] act;
                it  = q.pop_front();
                act = {sd_o, sh_o, sl_o, sg_o, b1_o, b2_o};
                n_cmp++;
                if (it.due < cyc) begin
                    n_bad++;
                    $display("FAIL %s: item due %0d missed at %0d", it.req, it.due, cyc);
                end else if (act !== it.sw || (it.chk_so && so !== it.so)) begin
                    n_bad++;
                    $display("FAIL %s: sw=%b so=%b expected sw=%b so=%b (cycle %0d)",
                             it.req, act, so, it.sw, it.so, cyc);
                end
            end
        end
    end

    // capture, shift w in LSB first, update; checks every step
    task automatic load_word(logic [3:0] w, logic c);
        logic [3:0] cells;
        @(negedge clk);
        cap = 1'b1; cmp = c;
        cells = {held[3:1], c};
        push(cyc + 1, 1'b1, c, exp_sw(ir, held), "R2");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cap = 1'b0; sh = 1'b1; sin = w[i];
            cells = {w[i], cells[3:1]};
            push(cyc + 1, 1'b1, cells[0], exp_sw(ir, held), "R3/R4");
        end
        @(negedge clk);
        sh = 1'b0; upd = 1'b1;
        push(cyc + 1, 1'b1, w[0], exp_sw(ir, w), "R4 update");
        held = w;
        @(negedge clk);
        upd = 1'b0;
    endtask

    task automatic set_ir(logic [3:0] v, string req);
        @(negedge clk);
        ir = v;
        push(cyc, 1'b0, 1'b0, exp_sw(v, held), req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        trst_n = 1'b1;
        push(cyc, 1'b1, 1'b0, 6'b100000, "R1");
        set_ir(4'h0, "R6");
        load_word(4'h0, 1'b1);   // R6
        load_word(4'h3, 1'b0);   // R7
        load_word(4'hD, 1'b1);   // R8
        load_word(4'hE, 1'b0);   // R8
        load_word(4'h7, 1'b1);   // R9
        load_word(4'hB, 1'b1);   // R9
        load_word(4'h5, 1'b0);   // R10
        load_word(4'hF, 1'b1);   // R10
        load_word(4'h9, 1'b0);   // R10
        load_word(4'hB, 1'b0);
        set_ir(4'h2, "R5");
        load_word(4'h3, 1'b1);   // R5 word ignored
        set_ir(4'h0, "R7");
        set_ir(4'hA, "R5");
        @(negedge clk);
        trst_n = 1'b0; held = 4'h0;
        push(cyc, 1'b1, 1'b0, 6'b100000, "R1");
        @(negedge clk);
        trst_n = 1'b1;
        set_ir(4'h0, "R1");
        load_word(4'hD, 1'b0);   // capture after reset returns held bits 0
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_bad += q.size();
            $display("FAIL queue: %0d items unchecked, expected 0", q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule